// File: doc/BRIEF.md
# Multi-Mode Memory Address Generator

This unit forms the effective address of a load or store from a small set of operands: a base register value, an index register value, a two-bit scale code, a raw displacement with a width code, the current program counter and an access-size code. A three-bit mode select chooses how those operands combine. The unit also reports whether the base register must be updated, and with what value, and it flags accesses whose address is not a multiple of the access size.

Two modes update the base. Post-increment uses the base unchanged as the address and then advances the base by the access size in bytes. Pre-index uses base plus displacement as the address and stores that same sum back into the base. The memory-indirect mode needs a second memory lookup that this unit does not perform. Instead, it raises a request that carries the first address, and it gives no final address in that cycle.

The arithmetic is combinational and every result is captured in registers. A strobe on `in_valid` therefore produces a result one clock later, marked by `out_valid`. The register file and the memory system sit outside this block.

Top module: `addr_gen_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. While reset is held and after it, every output is zero until the first strobe.
- R2: The displacement is sign-extended from its low 8 bits (width code 00), from its low 16 bits (01), or used whole as 32 bits (10 or 11).
- R3: Mode 000 (and the spare code 111, which behaves the same way) gives address = base + displacement, with no writeback and no indirect request.
- R4: Mode 001 gives address = base + index. The displacement is not used.
- R5: Mode 010 gives address = base + index × scale + displacement, where scale code 00, 01, 10 and 11 selects ×1, ×2, ×4 and ×8.
- R6: Mode 011 gives address = base and asserts `wb_en` with `wb_val` = base + access bytes.
- R7: Mode 100 gives address = base + displacement and asserts `wb_en` with `wb_val` equal to that address.
- R8: Mode 101 gives address = PC + displacement, with no writeback.
- R9: Mode 110 asserts `ind_req` with `ind_addr` = base, drives `out_ea` to zero, and raises neither `wb_en` nor `misaligned`.
- R10: Size codes 00, 01, 10 and 11 mean 1, 2, 4 and 8 bytes. `misaligned` is set when the address is not a multiple of the size. A byte access is never flagged.
- R11: A cycle with `in_valid` low makes `out_valid`, `wb_en`, `ind_req` and `misaligned` zero on the next cycle, and `out_ea` keeps its previous value.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid strobe |
| in_mode | input | 3 | Addressing mode select |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_scale | input | 2 | Index scale code |
| in_disp | input | 32 | Raw displacement field |
| in_dwidth | input | 2 | Displacement width code |
| in_pc | input | 32 | Current program counter |
| in_size | input | 2 | Access size code |
| out_valid | output | 1 | Result valid |
| out_ea | output | 32 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | New base value |
| misaligned | output | 1 | Address not a multiple of the access size |
| ind_req | output | 1 | Indirect lookup request |
| ind_addr | output | 32 | Address of the first indirect lookup |

## Verification
The bench targets displacements whose sign bit sits at bit 7 or bit 15, where a unit that zero-extends or picks the wrong width would land thousands of bytes away. It drives every scale code and every size code through the scaled and post-increment modes. A shift off by one position there would double or halve the stride. It also drives base values near 2^32 so that wrong carry handling appears as a non-wrapped address. Alignment is probed just below each size boundary: a flag raised on byte accesses, or one that tests the wrong low bits, shows up at once. Idle cycles between strobes expose writeback or indirect pulses that stay high, and an address that fails to hold its value.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam int DISP_W = 32;

   typedef enum logic [2:0] {
      MODE_DISP    = 3'd0,
      MODE_INDEX   = 3'd1,
      MODE_SCALED  = 3'd2,
      MODE_POSTINC = 3'd3,
      MODE_PREIDX  = 3'd4,
      MODE_PCREL   = 3'd5,
      MODE_INDIR   = 3'd6,
      MODE_SPARE   = 3'd7
   } agu_mode_e;

   typedef enum logic [1:0] {
      DW_8  = 2'd0,
      DW_16 = 2'd1,
      DW_32 = 2'd2,
      DW_XX = 2'd3
   } agu_dw_e;
endpackage

// File: rtl/agu_sext.sv
module agu_sext #(
   parameter int ADDR_W = 32
) (
   input  logic [agu_pkg::DISP_W-1:0] raw,
   input  logic [1:0]                 dw,
   output logic [ADDR_W-1:0]          ext
);
   always_comb begin
      unique case (dw)
         2'd0:    ext = ADDR_W'(signed'(raw[7:0]));
         2'd1:    ext = ADDR_W'(signed'(raw[15:0]));
         default: ext = ADDR_W'(signed'(raw));
      endcase
   end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
   parameter int ADDR_W  = 32,
   parameter int SCALE_W = 2
) (
   input  logic [ADDR_W-1:0]  idx,
   input  logic [SCALE_W-1:0] sc,
   output logic [ADDR_W-1:0]  scaled
);
   localparam int N_SCALE = 1 << SCALE_W;

   logic [ADDR_W-1:0] cand [N_SCALE];

   for (genvar s = 0; s < N_SCALE; s++) begin : g_cand
      assign cand[s] = idx << s;
   end

   assign scaled = cand[sc];
endmodule

// File: rtl/agu_align.sv
module agu_align #(
   parameter int ADDR_W   = 32,
   parameter int SIZE_W   = 2,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              bad
);
   localparam int N_SIZE = 1 << SIZE_W;

   if (CHECK_EN) begin : g_check
      logic [N_SIZE-1:0] hit;
      for (genvar k = 0; k < N_SIZE; k++) begin : g_sz
         if (k == 0) begin : g_byte
            assign hit[k] = 1'b0;
         end else begin : g_wide
            assign hit[k] = |addr[k-1:0];
         end
      end
      assign bad = hit[size];
   end else begin : g_nocheck
      assign bad = 1'b0;
   end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
   parameter int ADDR_W    = 32,
   parameter int SCALE_W   = 2,
   parameter int SIZE_W    = 2,
   parameter bit ALIGN_CHK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        in_mode,
   input  logic [31:0]       in_base,
   input  logic [31:0]       in_index,
   input  logic [1:0]        in_scale,
   input  logic [31:0]       in_disp,
   input  logic [1:0]        in_dwidth,
   input  logic [31:0]       in_pc,
   input  logic [1:0]        in_size,
   output logic              out_valid,
   output logic [31:0]       out_ea,
   output logic              wb_en,
   output logic [31:0]       wb_val,
   output logic              misaligned,
   output logic              ind_req,
   output logic [31:0]       ind_addr
);
   import agu_pkg::*;

   if (ADDR_W != 32) begin : g_bad_aw
      $error("addr_gen_unit: ADDR_W must be 32");
   end
   if (SCALE_W != 2 || SIZE_W != 2) begin : g_bad_codes
      $error("addr_gen_unit: scale and size codes are two bits");
   end

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] idx_scaled;
   logic [ADDR_W-1:0] base_disp;
   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] nxt_ea;
   logic [ADDR_W-1:0] nxt_wb_val;
   logic              nxt_wb;
   logic              nxt_ind;
   logic              nxt_bad;
   logic              align_bad;

   agu_sext #(.ADDR_W(ADDR_W)) u_sext (
      .raw (in_disp),
      .dw  (in_dwidth),
      .ext (disp_ext)
   );

   agu_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) u_scale (
      .idx    (in_index),
      .sc     (in_scale),
      .scaled (idx_scaled)
   );

   assign base_disp = in_base + disp_ext;
   assign step      = ADDR_W'(1) << in_size;

   always_comb begin
      nxt_ea     = base_disp;
      nxt_wb     = 1'b0;
      nxt_wb_val = base_disp;
      nxt_ind    = 1'b0;
      unique case (agu_mode_e'(in_mode))
         MODE_INDEX:   nxt_ea = in_base + in_index;
         MODE_SCALED:  nxt_ea = base_disp + idx_scaled;
         MODE_POSTINC: begin
            nxt_ea     = in_base;
            nxt_wb     = 1'b1;
            nxt_wb_val = in_base + step;
         end
         MODE_PREIDX:  nxt_wb = 1'b1;
         MODE_PCREL:   nxt_ea = in_pc + disp_ext;
         MODE_INDIR: begin
            nxt_ea  = '0;
            nxt_ind = 1'b1;
         end
         default:      nxt_ea = base_disp;
      endcase
   end

   agu_align #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CHECK_EN(ALIGN_CHK)) u_align (
      .addr (nxt_ea),
      .size (in_size),
      .bad  (align_bad)
   );

   assign nxt_bad = align_bad & ~nxt_ind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_ea     <= '0;
         wb_en      <= 1'b0;
         wb_val     <= '0;
         misaligned <= 1'b0;
         ind_req    <= 1'b0;
         ind_addr   <= '0;
      end else begin
         out_valid  <= in_valid;
         wb_en      <= in_valid & nxt_wb;
         ind_req    <= in_valid & nxt_ind;
         misaligned <= in_valid & nxt_bad;
         if (in_valid) begin
            out_ea   <= nxt_ea;
            wb_val   <= nxt_wb_val;
            ind_addr <= in_base;
         end
      end
   end
endmodule

// File: rtl/agu_chk.sv
module agu_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [2:0]  in_mode,
   input logic [31:0] in_base,
   input logic [1:0]  in_size,
   input logic        out_valid,
   input logic [31:0] out_ea,
   input logic        wb_en,
   input logic [31:0] wb_val,
   input logic        misaligned,
   input logic        ind_req,
   input logic [31:0] ind_addr
);
   // R1
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !wb_en && !ind_req && !misaligned && $stable(out_ea)));

   // R6
   postinc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'd3) |=> (wb_en && out_ea == $past(in_base)));

   // R9
   indirect_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'd6) |=> (ind_req && !wb_en && !misaligned && ind_addr == $past(in_base)));

   // R10
   byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'd0) |=> !misaligned);

   // R8
   pcrel_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'd5) |=> (!wb_en && !ind_req));

   // R7
   preidx_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 3'd4) |=> (wb_en && wb_val == out_ea));
endmodule

bind addr_gen_unit agu_chk u_chk (.*);

// File: tb/sim_addr_gen_unit.sv
`timescale 1ns/1ps
module sim_addr_gen_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_mode = '0;
   logic [31:0] in_base = '0, in_index = '0, in_disp = '0, in_pc = '0;
   logic [1:0]  in_scale = '0, in_dwidth = '0, in_size = '0;
   logic        out_valid, wb_en, misaligned, ind_req;
   logic [31:0] out_ea, wb_val, ind_addr;

   int checks = 0;
   int errors = 0;
   bit running = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   addr_gen_unit u0 (.*);

   // behavioural reference model state
   bit          m_valid = 0, m_wb = 0, m_ind = 0, m_bad = 0;
   logic [31:0] m_ea = 0, m_wbv = 0, m_ia = 0;
   int          m_mode = 0;

   function automatic longint sext(input logic [31:0] d, input int code);
      longint v;
      if (code == 0)      v = (d[7:0]  >= 128)   ? longint'(d[7:0])  - 256   : longint'(d[7:0]);
      else if (code == 1) v = (d[15:0] >= 32768) ? longint'(d[15:0]) - 65536 : longint'(d[15:0]);
      else                v = d[31]              ? longint'(d) - 64'h1_0000_0000 : longint'(d);
      return v;
   endfunction

   function automatic logic [31:0] wrap(input longint v);
      return 32'(v & 64'hFFFF_FFFF);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 0; m_wb <= 0; m_ind <= 0; m_bad <= 0;
         m_ea <= 0; m_wbv <= 0; m_ia <= 0;
      end else begin
         longint d, ea;
         int bytes;
         d = sext(in_disp, int'(in_dwidth));
         bytes = 1;
         for (int k = 0; k < int'(in_size); k++) bytes = bytes * 2;
         m_valid <= in_valid;
         m_wb <= 0; m_ind <= 0; m_bad <= 0;
         if (in_valid) begin
            m_mode <= int'(in_mode);
            ea = 0;
            case (int'(in_mode))
               1: ea = longint'(in_base) + longint'(in_index);
               2: ea = longint'(in_base) + longint'(in_index) * (1 << int'(in_scale)) + d;
               3: begin ea = longint'(in_base); m_wb <= 1; m_wbv <= wrap(ea + bytes); end
               4: begin ea = longint'(in_base) + d; m_wb <= 1; m_wbv <= wrap(ea); end
               5: ea = longint'(in_pc) + d;
               6: begin ea = 0; m_ind <= 1; m_ia <= in_base; end
               default: ea = longint'(in_base) + d;
            endcase
            m_ea <= wrap(ea);
            if (int'(in_mode) != 6) m_bad <= (wrap(ea) % bytes) != 0;
         end
      end
   end

   function automatic string mtag(input int m);
      case (m)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         if (!rst_n) begin
            // R1 reset state
            chk(out_valid == 0 && wb_en == 0 && ind_req == 0 && misaligned == 0 && out_ea == 0,
                "R1", "reset state", out_ea, 32'h0);
         end else begin
            chk(out_valid == m_valid, "R1", "out_valid", 32'(out_valid), 32'(m_valid));
            if (m_valid) begin
               chk(out_ea == m_ea, mtag(m_mode), "out_ea", out_ea, m_ea);
               chk(wb_en == m_wb, mtag(m_mode), "wb_en", 32'(wb_en), 32'(m_wb));
               if (m_wb) chk(wb_val == m_wbv, mtag(m_mode), "wb_val", wb_val, m_wbv);
               chk(ind_req == m_ind, "R9", "ind_req", 32'(ind_req), 32'(m_ind));
               if (m_ind) chk(ind_addr == m_ia, "R9", "ind_addr", ind_addr, m_ia);
               chk(misaligned == m_bad, "R10", "misaligned", 32'(misaligned), 32'(m_bad));
            end else begin
               // R11 idle cycle: flags low, address held
               chk(!wb_en && !ind_req && !misaligned, "R11", "idle flags",
                   {29'b0, wb_en, ind_req, misaligned}, 32'h0);
               chk(out_ea == m_ea, "R11", "held out_ea", out_ea, m_ea);
            end
         end
      end
   end

   task automatic op(input int mode, input logic [31:0] base, input logic [31:0] idx,
                     input int sc, input logic [31:0] disp, input int dw,
                     input logic [31:0] pc, input int sz);
      @(negedge clk);
      in_valid = 1'b1; in_mode = 3'(mode); in_base = base; in_index = idx;
      in_scale = 2'(sc); in_disp = disp; in_dwidth = 2'(dw); in_pc = pc; in_size = 2'(sz);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; in_mode = 3'(3); in_base = $urandom; in_disp = $urandom;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      running = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R2 / R3: 8-bit negative displacement, 16-bit, 32-bit, spare code
      op(0, 32'h0000_1000, 0, 0, 32'h0000_00F0, 0, 0, 0);
      op(0, 32'h0010_0000, 0, 0, 32'h1234_8000, 1, 0, 0);
      op(0, 32'h0000_0010, 0, 0, 32'hFFFF_FFF0, 2, 0, 2);
      op(7, 32'h0000_2000, 0, 0, 32'h0000_0080, 0, 0, 0);
      op(0, 32'h0000_0100, 0, 0, 32'h0000_7FFF, 3, 0, 0);
      // R4 / R12: index wrap
      op(1, 32'hFFFF_FFFF, 32'h2, 0, 32'hDEAD_BEEF, 2, 0, 0);
      // R5: every scale
      for (int s = 0; s < 4; s++) op(2, 32'h1000, 32'h3, s, 32'h0000_00FC, 0, 0, 2);
      idle();
      // R6: every size for post-increment
      for (int z = 0; z < 4; z++) op(3, 32'h0000_0100, 0, 0, 0, 0, 0, z);
      op(3, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 2);
      // R7: pre-index negative
      op(4, 32'h0000_0400, 0, 0, 32'h0000_FFF8, 1, 0, 3);
      // R8: pc-relative
      op(5, 32'h5555_5555, 0, 0, 32'h0000_0010, 0, 32'h0000_8000, 2);
      // R9: indirect
      op(6, 32'h0000_3003, 0, 0, 32'h44, 0, 0, 2);
      idle(); idle();
      // R10: boundary alignment
      op(0, 32'h0000_1001, 0, 0, 0, 0, 0, 1);
      op(0, 32'h0000_1002, 0, 0, 0, 0, 0, 2);
      op(0, 32'h0000_1004, 0, 0, 0, 0, 0, 3);
      op(0, 32'h0000_1008, 0, 0, 0, 0, 0, 3);
      op(0, 32'h0000_1003, 0, 0, 0, 0, 0, 0);
      idle();
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 4) == 0) idle();
         else op($urandom_range(0, 7), $urandom, $urandom, $urandom_range(0, 3), $urandom,
                 $urandom_range(0, 3), $urandom, $urandom_range(0, 3));
      end
      idle(); idle();
      @(negedge clk);
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule